// File: doc/BRIEF.md
# Sub-blocked Direct-Mapped Write-Through Data Cache

This block is a level-one data cache that sits between a load/store unit and a simple memory port. It is direct-mapped and uses the virtual address for both the line index and the tag, so a lookup never waits for translation. Each line has one tag and two 16-byte sub-blocks. Each sub-block has its own valid bit, so a line can hold one half without the other.

A load that hits returns its word in the cycle after the request is accepted. A load that misses fetches only the addressed 16-byte sub-block from memory, writes it into the array and runs the lookup again. The replayed lookup then hits and returns the word. Stores are always forwarded to memory. A store that hits also merges its bytes into the cached copy. A store that misses leaves the cache untouched. Only one request is in flight at a time, and the CPU side stays not-ready until that request has finished.

The full-size configuration has 512 lines, which is 16 KB of data. The line count, address width and word width are parameters, so a small instance can be used for simulation.

Top module: `subblock_dcache`

## Requirements
- R1: After reset, every sub-block is invalid. `cpuReqReady` is 1, and `cpuRespValid` and `memReqValid` are 0. The first load to any address misses.
- R2: A load whose sub-block is valid and whose tag matches the line tag returns its word with `cpuRespValid` high in the first cycle after acceptance. It issues no memory request, and the cache is ready again in the cycle after the response.
- R3: A load miss issues exactly one memory read. The read address is the load address with its low 4 bits cleared. Word w of the refill is taken from `memRespData[w*DATA_W +: DATA_W]`, where word w sits at byte offset w*DATA_W/8 in the sub-block. After the refill the load is replayed and returns the refilled word.
- R4: Valid bits are kept per sub-block. Filling one half of a line does not make the other half hit. A later fill of the other half, under the same tag, keeps the first half valid.
- R5: A refill whose tag differs from the line's stored tag installs the new tag and invalidates the other sub-block of that line. Lines at other indexes are not affected.
- R6: Every store, hit or miss, produces exactly one memory write. The write carries the store data, the store byte enables, and the store address with its low log2(DATA_W/8) bits cleared.
- R7: A store that hits updates only the cached bytes whose byte enable is set (bit b covers data bits [8b+7:8b]). A following load to that word hits and returns the merged value.
- R8: A store that misses does not allocate a line and does not read memory. A following load to that sub-block misses.
- R9: Only one request is outstanding at a time. `cpuReqReady` is low from the cycle after acceptance until the load has responded or the store's memory write has been accepted. A request held valid during that time is not taken.
- R10: `cpuRespValid` pulses exactly once for each load and never for a store.
- R11: Address fields for a 32-bit word: byte offset in bits [1:0], word in bits [3:2], sub-block select in bit 4, line index in the next log2(LINES) bits, and tag in the remaining upper bits.
- R12: Once `memReqValid` is raised, it stays high with an unchanged address and direction until `memReqReady` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cpuReqValid | input | 1 | CPU request valid |
| cpuReqReady | output | 1 | Cache can accept a request |
| cpuReqWrite | input | 1 | 1 = store, 0 = load |
| cpuReqAddr | input | ADDR_W | Virtual byte address |
| cpuReqWdata | input | DATA_W | Store data |
| cpuReqBe | input | DATA_W/8 | Store byte enables |
| cpuRespValid | output | 1 | Load data valid |
| cpuRespData | output | DATA_W | Load data |
| memReqValid | output | 1 | Memory request valid |
| memReqReady | input | 1 | Memory accepts the request |
| memReqWrite | output | 1 | 1 = word write, 0 = sub-block read |
| memReqAddr | output | ADDR_W | Memory byte address |
| memReqWdata | output | DATA_W | Write data |
| memReqBe | output | DATA_W/8 | Write byte enables |
| memRespValid | input | 1 | Refill data valid |
| memRespReady | output | 1 | Cache waits for refill data |
| memRespData | input | 128 | One 16-byte sub-block |

## Verification
The assertions check the handshake rules on every cycle:
- the memory request is aligned and held steady until it is accepted;
- the CPU side is blocked while a memory transaction is open;
- a response is followed by a return to ready;
- a refill leads to a replay cycle.

Which sub-block is valid under which tag can only be seen through traffic over time. The bench therefore keeps its own tag and valid image of the small configuration and sweeps every tag, index, sub-block and word. For each load it predicts the hit latency and the read count. The byte merging of store hits, non-allocation on store misses, tag replacement clearing the neighbouring half, and a request held off during a miss are shown only by these scenarios.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int SUB_BYTES = 16;
  localparam int SUB_BITS = SUB_BYTES * 8;
  localparam int SUB_OFS_W = $clog2(SUB_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_STORE,
    ST_FILL_REQ,
    ST_FILL_WAIT
  } ctrlState_t;

  typedef struct packed {
    logic capture;   // latch a new CPU request
    logic storeHit;  // merge store bytes into the cached sub-block
    logic fill;      // write refill data, tag and valid bit
  } dpStrobe_t;
endpackage

// File: rtl/sbc_valid_table.sv
module sbc_valid_table #(
  parameter int LINES = 512,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] lineIdx,
  input  logic             fillEn,
  input  logic             fillSb,
  input  logic             clearOther,
  output logic [1:0]       validOut
);
  for (genvar g = 0; g < 2; g++) begin : g_half
    logic [LINES-1:0] vBits;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vBits <= '0;
      end else if (fillEn) begin
        if (fillSb == 1'(g)) begin
          vBits[lineIdx] <= 1'b1;
        end else if (clearOther) begin
          vBits[lineIdx] <= 1'b0;
        end
      end
    end
    assign validOut[g] = vBits[lineIdx];
  end
endmodule

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES = 512,
  localparam int BE_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              cpuReqWrite,
  input  logic [ADDR_W-1:0] cpuReqAddr,
  input  logic [DATA_W-1:0] cpuReqWdata,
  input  logic [BE_W-1:0]   cpuReqBe,
  input  logic [SUB_BITS-1:0] memRespData,
  output logic              reqWrite,
  output logic              hit,
  output logic [DATA_W-1:0] rdWord,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [BE_W-1:0]   memBe
);
  localparam int BSEL_W = $clog2(BE_W);
  localparam int WSEL_W = SUB_OFS_W - BSEL_W;
  localparam int IDX_W = $clog2(LINES);
  localparam int IDX_LSB = SUB_OFS_W + 1;
  localparam int TAG_W = ADDR_W - IDX_LSB - IDX_W;
  localparam int ROWS = 2 * LINES;

  logic [ADDR_W-1:BSEL_W] addrQ;
  logic [DATA_W-1:0]      wdataQ;
  logic [BE_W-1:0]        beQ;
  logic                   writeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      writeQ <= 1'b0;
    end else if (strobe.capture) begin
      addrQ  <= cpuReqAddr[ADDR_W-1:BSEL_W];
      wdataQ <= cpuReqWdata;
      beQ    <= cpuReqBe;
      writeQ <= cpuReqWrite;
    end
  end

  logic [TAG_W-1:0]  reqTag;
  logic [IDX_W-1:0]  reqIdx;
  logic              reqSb;
  logic [WSEL_W-1:0] reqWord;
  logic [IDX_W:0]    rowSel;

  assign reqTag  = addrQ[ADDR_W-1 -: TAG_W];
  assign reqIdx  = addrQ[IDX_LSB +: IDX_W];
  assign reqSb   = addrQ[SUB_OFS_W];
  assign reqWord = addrQ[BSEL_W +: WSEL_W];
  assign rowSel  = {reqIdx, reqSb};

  logic [TAG_W-1:0]    tagMem  [LINES];
  logic [SUB_BITS-1:0] dataMem [ROWS];

  logic [TAG_W-1:0]    storedTag;
  logic                tagMatch;
  logic [1:0]          validPair;
  logic [SUB_BITS-1:0] curSb;
  logic [SUB_BITS-1:0] merged;

  assign storedTag = tagMem[reqIdx];
  assign tagMatch  = (storedTag == reqTag);
  assign curSb     = dataMem[rowSel];
  assign hit       = tagMatch && validPair[reqSb];
  assign rdWord    = curSb[int'(reqWord)*DATA_W +: DATA_W];

  always_comb begin
    merged = curSb;
    for (int b = 0; b < BE_W; b++) begin
      if (beQ[b]) begin
        merged[int'(reqWord)*DATA_W + b*8 +: 8] = wdataQ[b*8 +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      dataMem[rowSel] <= memRespData;
      tagMem[reqIdx]  <= reqTag;
    end else if (strobe.storeHit) begin
      dataMem[rowSel] <= merged;
    end
  end

  sbc_valid_table #(.LINES(LINES)) i_validTable (
    .clk       (clk),
    .rstN      (rstN),
    .lineIdx   (reqIdx),
    .fillEn    (strobe.fill),
    .fillSb    (reqSb),
    .clearOther(!tagMatch),
    .validOut  (validPair)
  );

  assign reqWrite = writeQ;
  assign memAddr  = writeQ ? {addrQ, {BSEL_W{1'b0}}}
                           : {addrQ[ADDR_W-1:SUB_OFS_W], {SUB_OFS_W{1'b0}}};
  assign memWdata = wdataQ;
  assign memBe    = beQ;
endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cpuReqValid,
  input  logic      reqWrite,
  input  logic      hit,
  input  logic      memReqReady,
  input  logic      memRespValid,
  output logic      cpuReqReady,
  output logic      cpuRespValid,
  output logic      memReqValid,
  output logic      memReqWrite,
  output logic      memRespReady,
  output dpStrobe_t strobe
);
  ctrlState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:      if (cpuReqValid) nextState = ST_LOOKUP;
      ST_LOOKUP: begin
        if (reqWrite)  nextState = ST_STORE;
        else if (hit)  nextState = ST_IDLE;
        else           nextState = ST_FILL_REQ;
      end
      ST_STORE:     if (memReqReady) nextState = ST_IDLE;
      ST_FILL_REQ:  if (memReqReady) nextState = ST_FILL_WAIT;
      ST_FILL_WAIT: if (memRespValid) nextState = ST_LOOKUP;
      default:      nextState = ST_IDLE;
    endcase
  end

  assign cpuReqReady     = (state == ST_IDLE);
  assign cpuRespValid    = (state == ST_LOOKUP) && !reqWrite && hit;
  assign memReqValid     = (state == ST_STORE) || (state == ST_FILL_REQ);
  assign memReqWrite     = (state == ST_STORE);
  assign memRespReady    = (state == ST_FILL_WAIT);
  assign strobe.capture  = (state == ST_IDLE) && cpuReqValid;
  assign strobe.storeHit = (state == ST_LOOKUP) && reqWrite && hit;
  assign strobe.fill     = (state == ST_FILL_WAIT) && memRespValid;
endmodule

// File: rtl/subblock_dcache.sv
module subblock_dcache
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES = 512
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cpuReqValid,
  output logic                cpuReqReady,
  input  logic                cpuReqWrite,
  input  logic [ADDR_W-1:0]   cpuReqAddr,
  input  logic [DATA_W-1:0]   cpuReqWdata,
  input  logic [DATA_W/8-1:0] cpuReqBe,
  output logic                cpuRespValid,
  output logic [DATA_W-1:0]   cpuRespData,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic                memReqWrite,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [DATA_W-1:0]   memReqWdata,
  output logic [DATA_W/8-1:0] memReqBe,
  input  logic                memRespValid,
  output logic                memRespReady,
  input  logic [SUB_BITS-1:0] memRespData
);
  dpStrobe_t strobe;
  logic      reqWrite;
  logic      hit;

  sbc_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .cpuReqValid (cpuReqValid),
    .reqWrite    (reqWrite),
    .hit         (hit),
    .memReqReady (memReqReady),
    .memRespValid(memRespValid),
    .cpuReqReady (cpuReqReady),
    .cpuRespValid(cpuRespValid),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .memRespReady(memRespReady),
    .strobe      (strobe)
  );

  sbc_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cpuReqWrite(cpuReqWrite),
    .cpuReqAddr (cpuReqAddr),
    .cpuReqWdata(cpuReqWdata),
    .cpuReqBe   (cpuReqBe),
    .memRespData(memRespData),
    .reqWrite   (reqWrite),
    .hit        (hit),
    .rdWord     (cpuRespData),
    .memAddr    (memReqAddr),
    .memWdata   (memReqWdata),
    .memBe      (memReqBe)
  );
endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cpuReqValid,
  input logic              cpuReqReady,
  input logic              cpuRespValid,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              memRespValid,
  input logic              memRespReady
);
  localparam int BSEL_W = $clog2(DATA_W / 8);

  assert_busy_while_mem_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || memRespReady) |-> !cpuReqReady);

  assert_accept_then_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuReqValid && cpuReqReady) |=> !cpuReqReady);

  assert_fill_aligned_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqWrite) |-> (memReqAddr[3:0] == 4'h0));

  assert_write_aligned_R6: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && memReqWrite) |-> (memReqAddr[BSEL_W-1:0] == '0));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite)));

  assert_resp_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    cpuRespValid |-> (!cpuReqReady && !memReqValid));

  assert_resp_then_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    cpuRespValid |=> cpuReqReady);

  assert_fill_replays_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memRespValid && memRespReady) |=> (!cpuReqReady && !memReqValid && !memRespReady));
endmodule

bind subblock_dcache sbc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sbcChecker (
  .clk         (clk),
  .rstN        (rstN),
  .cpuReqValid (cpuReqValid),
  .cpuReqReady (cpuReqReady),
  .cpuRespValid(cpuRespValid),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqWrite (memReqWrite),
  .memReqAddr  (memReqAddr),
  .memRespValid(memRespValid),
  .memRespReady(memRespReady)
);

// File: tb/test_subblock_dcache.sv
`timescale 1ns/1ps
module test_subblock_dcache;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuReqValid = 1'b0, cpuReqReady, cpuReqWrite = 1'b0;
  logic [AW-1:0] cpuReqAddr = '0;
  logic [DW-1:0] cpuReqWdata = '0;
  logic [3:0] cpuReqBe = '0;
  logic cpuRespValid;
  logic [DW-1:0] cpuRespData;
  logic memReqValid, memReqReady = 1'b1, memReqWrite;
  logic [AW-1:0] memReqAddr;
  logic [DW-1:0] memReqWdata;
  logic [3:0] memReqBe;
  logic memRespValid = 1'b0, memRespReady;
  logic [127:0] memRespData = '0;

  always #2.5 clk = ~clk;

  subblock_dcache #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) i_subblock_dcache (.*);

  int total = 0, bad = 0;
  logic [31:0] mem [256];
  logic [31:0] refMem [256];
  int memReads = 0, memWrites = 0;
  logic [AW-1:0] lastRdAddr = '0, lastWrAddr = '0;
  logic [3:0] lastWrBe = '0;
  logic [AW-1:0] pendAddr = '0;
  int respDelay = 0;
  int rdyCnt = 0;
  logic [2:0] mTag [NL];
  bit mValid [NL][2];

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mkAddr(int t, int i, int s, int w);
    return {3'(t), 2'(i), 1'(s), 2'(w), 2'b00};
  endfunction

  // memory model: ready pattern, write apply, delayed refill
  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i] = {8'(i) ^ 8'h5A, 8'(i), ~8'(i), 8'(i) + 8'h33};
      refMem[i] = mem[i];
    end
    forever begin
      @(negedge clk);
      if (memRespValid) memRespValid = 1'b0;
      if (respDelay > 0) begin
        respDelay--;
        if (respDelay == 0) begin
          for (int w = 0; w < 4; w++)
            memRespData[w*32 +: 32] = mem[{pendAddr[9:4], 2'(w)}];
          memRespValid = 1'b1;
        end
      end
      rdyCnt++;
      memReqReady = (rdyCnt % 3) != 0;
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          for (int b = 0; b < 4; b++)
            if (memReqBe[b]) mem[memReqAddr[9:2]][b*8 +: 8] = memReqWdata[b*8 +: 8];
          memWrites++;
          lastWrAddr = memReqAddr;
          lastWrBe = memReqBe;
        end else begin
          memReads++;
          lastRdAddr = memReqAddr;
          pendAddr = memReqAddr;
          respDelay = 2;
        end
      end
    end
  end

  task automatic modelFill(input logic [AW-1:0] a);
    int idx, sb;
    idx = int'(a[6:5]);
    sb = int'(a[4]);
    if (mTag[idx] != a[9:7]) mValid[idx][1-sb] = 0;
    mTag[idx] = a[9:7];
    mValid[idx][sb] = 1;
  endtask

  function automatic bit modelHit(input logic [AW-1:0] a);
    return mValid[int'(a[6:5])][int'(a[4])] && (mTag[int'(a[6:5])] == a[9:7]);
  endfunction

  task automatic doLoad(input logic [AW-1:0] a, input string rq);
    bit expHit;
    int rb, waited;
    expHit = modelHit(a);
    rb = memReads;
    @(negedge clk);
    while (!cpuReqReady) @(negedge clk);
    cpuReqValid = 1'b1; cpuReqWrite = 1'b0; cpuReqAddr = a; cpuReqBe = '0;
    @(negedge clk);
    cpuReqValid = 1'b0;
    waited = 0;
    while (!cpuRespValid && waited < 200) begin @(negedge clk); waited++; end
    check(cpuRespData == refMem[a[9:2]], rq, "load data", cpuRespData, refMem[a[9:2]]);
    check(expHit ? (waited == 0) : (waited > 0 && waited < 200), rq, "hit/miss latency",
          32'(waited), expHit ? 32'd0 : 32'd1);
    check((memReads - rb) == (expHit ? 0 : 1), rq, "memory reads",
          32'(memReads - rb), expHit ? 32'd0 : 32'd1);
    if (!expHit) begin
      check(lastRdAddr == {a[9:4], 4'h0}, "R3 R12", "refill address",
            32'(lastRdAddr), 32'({a[9:4], 4'h0}));
      modelFill(a);
    end
    @(negedge clk);
    check(!cpuRespValid, "R10", "single response pulse", 32'(cpuRespValid), 32'd0);
  endtask

  task automatic doStore(input logic [AW-1:0] a, input logic [31:0] d,
                         input logic [3:0] be, input string rq);
    int wb, rb, waited;
    bit sawResp;
    wb = memWrites;
    rb = memReads;
    for (int b = 0; b < 4; b++) if (be[b]) refMem[a[9:2]][b*8 +: 8] = d[b*8 +: 8];
    @(negedge clk);
    while (!cpuReqReady) @(negedge clk);
    cpuReqValid = 1'b1; cpuReqWrite = 1'b1; cpuReqAddr = a; cpuReqWdata = d; cpuReqBe = be;
    @(negedge clk);
    cpuReqValid = 1'b0;
    waited = 0; sawResp = 0;
    while (!cpuReqReady && waited < 200) begin
      if (cpuRespValid) sawResp = 1;
      @(negedge clk); waited++;
    end
    check((memWrites - wb) == 1, rq, "one memory write", 32'(memWrites - wb), 32'd1);
    check(lastWrAddr == {a[9:2], 2'b00}, "R6", "write address", 32'(lastWrAddr), 32'({a[9:2], 2'b00}));
    check(lastWrBe == be, "R6", "write byte enables", 32'(lastWrBe), 32'(be));
    check(mem[a[9:2]] == refMem[a[9:2]], "R6", "memory word after store", mem[a[9:2]], refMem[a[9:2]]);
    check(!sawResp, "R10", "no response for store", 32'(sawResp), 32'd0);
    check(memReads == rb, "R8", "store reads no memory", 32'(memReads - rb), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin mTag[i] = '0; mValid[i][0] = 0; mValid[i][1] = 0; end
    repeat (4) @(negedge clk);
    check(cpuReqReady == 1'b1, "R1", "ready in reset", 32'(cpuReqReady), 32'd1);
    rstN = 1'b1;
    @(negedge clk);
    check(cpuReqReady == 1'b1, "R1", "ready after reset", 32'(cpuReqReady), 32'd1);
    check(!cpuRespValid && !memReqValid, "R1", "idle outputs", 32'({cpuRespValid, memReqValid}), 32'd0);

    // R1 first access misses, R3 refill, R2 hits on all words
    doLoad(mkAddr(0, 0, 0, 1), "R1 R3");
    for (int w = 0; w < 4; w++) doLoad(mkAddr(0, 0, 0, w), "R2");
    // R4 other half misses, first half still hits
    doLoad(mkAddr(0, 0, 1, 3), "R4");
    doLoad(mkAddr(0, 0, 0, 2), "R4");
    doLoad(mkAddr(0, 0, 1, 0), "R4");
    // R5 new tag at same index clears the other half, other index untouched
    doLoad(mkAddr(0, 1, 0, 0), "R5");
    doLoad(mkAddr(5, 0, 0, 1), "R5");
    doLoad(mkAddr(0, 0, 1, 1), "R5");
    doLoad(mkAddr(0, 0, 0, 1), "R5");
    doLoad(mkAddr(0, 1, 0, 3), "R5");
    check(modelHit(mkAddr(5, 0, 0, 0)) == 0, "R5", "model replaced tag", 32'd0, 32'd0);

    // R11 sweep: every tag, index, half and word
    for (int t = 0; t < 8; t++)
      for (int i = 0; i < NL; i++)
        for (int s = 0; s < 2; s++)
          for (int w = 0; w < 4; w++)
            doLoad(mkAddr(t, i, s, (w + t) % 4), "R11");
    for (int s = 1; s >= 0; s--)
      for (int t = 7; t >= 0; t -= 3)
        for (int i = NL - 1; i >= 0; i--)
          doLoad(mkAddr(t, i, s, i), "R11");

    // R7 store hits merge bytes
    doLoad(mkAddr(2, 3, 1, 0), "R7");
    doStore(mkAddr(2, 3, 1, 2), 32'hDEADBEEF, 4'b0001, "R6 R7");
    doLoad(mkAddr(2, 3, 1, 2), "R7");
    doStore(mkAddr(2, 3, 1, 2), 32'h12345678, 4'b0110, "R6 R7");
    doLoad(mkAddr(2, 3, 1, 2), "R7");
    doStore(mkAddr(2, 3, 1, 0), 32'hCAFEF00D, 4'b1000, "R6 R7");
    doLoad(mkAddr(2, 3, 1, 0), "R7");
    doStore(mkAddr(2, 3, 1, 3), 32'h0BADC0DE, 4'b1111, "R6 R7");
    doLoad(mkAddr(2, 3, 1, 3), "R7");

    // R8 store miss does not allocate
    doStore(mkAddr(6, 2, 0, 1), 32'h55AA33CC, 4'b1111, "R6 R8");
    check(modelHit(mkAddr(6, 2, 0, 1)) == 0, "R8", "line stays unallocated", 32'd0, 32'd0);
    doLoad(mkAddr(6, 2, 0, 1), "R8");

    // R9 store held valid during a load miss is not taken early
    begin
      logic [AW-1:0] la, sa;
      int wb, waited;
      la = mkAddr(3, 1, 1, 2);
      sa = mkAddr(4, 2, 1, 1);
      wb = memWrites;
      @(negedge clk);
      while (!cpuReqReady) @(negedge clk);
      cpuReqValid = 1'b1; cpuReqWrite = 1'b0; cpuReqAddr = la; cpuReqBe = '0;
      @(negedge clk);
      cpuReqWrite = 1'b1; cpuReqAddr = sa; cpuReqWdata = 32'h600DF00D; cpuReqBe = 4'b1111;
      waited = 0;
      while (!cpuRespValid && waited < 200) begin @(negedge clk); waited++; end
      check(cpuRespData == refMem[la[9:2]], "R9", "load data under held request",
            cpuRespData, refMem[la[9:2]]);
      check(memWrites == wb, "R9", "held store not taken", 32'(memWrites - wb), 32'd0);
      modelFill(la);
      refMem[sa[9:2]] = 32'h600DF00D;
      @(negedge clk);
      check(cpuReqReady == 1'b1, "R9", "ready after response", 32'(cpuReqReady), 32'd1);
      @(negedge clk);
      cpuReqValid = 1'b0;
      waited = 0;
      while (!cpuReqReady && waited < 200) begin @(negedge clk); waited++; end
      check(memWrites == wb + 1, "R9", "held store taken once", 32'(memWrites - wb), 32'd1);
      check(mem[sa[9:2]] == 32'h600DF00D, "R9", "held store data", mem[sa[9:2]], 32'h600DF00D);
      doLoad(la, "R9");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule